// File: doc/BRIEF.md
# Parallel Two-Bit-Correcting BCH Codec

This block protects a 256-bit word with 18 check bits and can repair up to two bit errors anywhere in the stored 274-bit word. It has two halves. The encoder is a flat XOR network that turns the data into its check bits within the same cycle. The decoder is a single combinational pass: it computes two syndromes, forms the error locator without any field division, and tests every bit position for a locator root at once. It then flips every position that is a root.

Field arithmetic uses GF(2^9) built on x^9 + x^4 + 1. The code is the binary length-511 BCH code of designed distance 5, shortened to 274 bits. Its generator is the product of the minimal polynomials of alpha and alpha^3. The decoder reports the repaired data, how many positions it flipped, and whether the word was beyond repair. An optional register stage holds the decoder outputs for one clock, so the logic cone can be closed at a clock edge.

Top module: `bch_codec`

## Requirements
- R1: Bit j of the 274-bit stored word {data, check} is the coefficient of x^j. Data bit i sits at position i+18 and check bit i at position i. For any data, the word formed with `enc_parity_o` evaluates to zero at alpha and at alpha^3, where alpha is a root of x^9 + x^4 + 1. `enc_parity_o` is valid in the same cycle as the data.
- R2: All-zero data gives all-zero check bits.
- R3: A valid stored word decodes to its data field, with `dec_nerr_o` = 0 and `dec_fail_o` = 0.
- R4: With exactly one flipped bit at any of the 274 positions, including positions 0 and 273, the decoder returns the original data, with `dec_nerr_o` = 1 and `dec_fail_o` = 0.
- R5: With exactly two flipped bits at any two distinct positions, the decoder returns the original data, with `dec_nerr_o` = 2 and `dec_fail_o` = 0.
- R6: Flips that fall only in check positions leave `dec_data_o` equal to the data field, and they are still counted in `dec_nerr_o`.
- R7: When `dec_fail_o` = 1, `dec_nerr_o` = 0 and `dec_data_o` equals the data field of the stored word exactly as presented.
- R8: With exactly three flipped bits, the decoder either raises `dec_fail_o`, or reports `dec_nerr_o` = 2 with at most two data bits changed. It never reports 0 or 1 corrections without raising the flag.
- R9: With `REG_OUT` = 1, the decoder outputs change only at a rising clock edge and reflect the word present at that edge. A synchronous, active-high `rst` forces all decoder outputs to zero.
- R10: `dec_data_o` never differs from the data field of the presented word in more bit positions than `dec_nerr_o` states.
- R11: `dec_nerr_o` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional decoder output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| enc_data_i | input | 256 | Data to be encoded |
| enc_parity_o | output | 18 | Check bits for `enc_data_i` |
| dec_word_i | input | 274 | Stored word to decode: data in bits 273..18, check in 17..0 |
| dec_data_o | output | 256 | Repaired data field |
| dec_nerr_o | output | 2 | Number of positions flipped (0, 1 or 2) |
| dec_fail_o | output | 1 | Word could not be repaired; data passed through |

## Verification
The assertions compare each registered output against the data field that was present at the preceding edge. They assume that `dec_word_i` is two-state and settled before every rising edge, and that `rst` is held high from time zero until the first edge. The bench drives all inputs on the falling edge and applies reset from the start, so both assumptions hold. It builds each decoder input from an encoder output plus a distinct-position flip mask of known weight. It never presents more than three flips, because a three-flip word may legitimately be repaired toward a neighbouring codeword, and only the weaker bound of R8 applies to it.

// File: rtl/bch_pkg.sv
package bch_pkg;
    localparam int M        = 9;                 // field degree
    localparam int Q        = (1 << M) - 1;      // multiplicative group order
    localparam int K        = 256;               // data bits
    localparam int P        = 2 * M;             // check bits
    localparam int N        = K + P;             // stored word length
    localparam int EXP_BITS = $clog2(3 * N);     // enough for every exponent used
    localparam int CW       = $clog2(N + 1);     // root counter width
    localparam logic [M:0] PRIM = 10'b10_0001_0001; // x^9 + x^4 + 1

    typedef logic [M-1:0] gf_t;

    typedef enum logic [1:0] {
        DK_CLEAN,
        DK_ONE,
        DK_TWO,
        DK_BAD
    } dec_kind_e;

    typedef struct packed {
        gf_t a;   // multiplies x^2 term (S1)
        gf_t b;   // multiplies x term (S1^2)
        gf_t c;   // constant term (S3 + S1^3)
    } loc_t;

    typedef struct packed {
        logic [K-1:0] data;
        logic [1:0]   nerr;
        logic         fail;
    } dec_res_t;

    function automatic gf_t gf_xtime(gf_t v);
        return {v[M-2:0], 1'b0} ^ (v[M-1] ? PRIM[M-1:0] : '0);
    endfunction

    function automatic gf_t gf_mul(gf_t x, gf_t y);
        gf_t acc;
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = gf_xtime(acc);
            if (y[i]) acc = acc ^ x;
        end
        return acc;
    endfunction

    function automatic gf_t gf_pow_alpha(int e);
        gf_t r;
        gf_t base;
        r    = gf_t'(1);
        base = gf_t'(2);
        for (int i = 0; i < EXP_BITS; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // Product of (x + alpha^e) over the cyclotomic classes of 1 and 3.
    function automatic logic [P:0] gen_poly();
        gf_t [P:0]  c;
        gf_t        r;
        int         e;
        logic [P:0] g;
        c    = '0;
        c[0] = gf_t'(1);
        for (int cls = 0; cls < 2; cls++) begin
            e = (cls == 0) ? 1 : 3;
            for (int j = 0; j < M; j++) begin
                r = gf_pow_alpha(e);
                for (int k = P; k >= 1; k--) c[k] = c[k-1] ^ gf_mul(c[k], r);
                c[0] = gf_mul(c[0], r);
                e = (2 * e) % Q;
            end
        end
        for (int k = 0; k <= P; k++) g[k] = c[k][0];
        return g;
    endfunction
endpackage

// File: rtl/bch_encoder.sv
module bch_encoder
    import bch_pkg::*;
(
    input  logic [K-1:0] data_i,
    output logic [P-1:0] parity_o
);
    localparam logic [P:0] GEN = gen_poly();

    // Unrolled remainder of data(x) * x^P modulo the generator.
    always_comb begin
        logic [P-1:0] rem;
        logic         fb;
        rem = '0;
        for (int i = K - 1; i >= 0; i--) begin
            fb  = data_i[i] ^ rem[P-1];
            rem = {rem[P-2:0], 1'b0} ^ (fb ? GEN[P-1:0] : '0);
        end
        parity_o = rem;
    end
endmodule

// File: rtl/bch_syndrome.sv
module bch_syndrome
    import bch_pkg::*;
(
    input  logic [N-1:0] word_i,
    output gf_t          s1_o,
    output gf_t          s3_o
);
    gf_t t1 [N];
    gf_t t3 [N];

    for (genvar j = 0; j < N; j++) begin : g_pos
        localparam gf_t A1 = gf_pow_alpha(j);
        localparam gf_t A3 = gf_pow_alpha(3 * j);
        assign t1[j] = word_i[j] ? A1 : '0;
        assign t3[j] = word_i[j] ? A3 : '0;
    end

    always_comb begin
        s1_o = '0;
        s3_o = '0;
        for (int j = 0; j < N; j++) begin
            s1_o = s1_o ^ t1[j];
            s3_o = s3_o ^ t3[j];
        end
    end
endmodule

// File: rtl/bch_locator.sv
module bch_locator
    import bch_pkg::*;
(
    input  gf_t  s1_i,
    input  gf_t  s3_i,
    output loc_t loc_o
);
    gf_t s1_sq;
    gf_t s1_cu;

    // Scaled locator: no division by S1 anywhere.
    assign s1_sq   = gf_mul(s1_i, s1_i);
    assign s1_cu   = gf_mul(s1_sq, s1_i);
    assign loc_o.a = s1_i;
    assign loc_o.b = s1_sq;
    assign loc_o.c = s3_i ^ s1_cu;
endmodule

// File: rtl/bch_root_search.sv
module bch_root_search
    import bch_pkg::*;
(
    input  loc_t         loc_i,
    output logic [N-1:0] hit_o
);
    // Position j is an error when a*X^2 + b*X + c = 0 with X = alpha^j.
    for (genvar j = 0; j < N; j++) begin : g_eval
        localparam gf_t X1 = gf_pow_alpha(j);
        localparam gf_t X2 = gf_pow_alpha(2 * j);
        assign hit_o[j] = ((gf_mul(loc_i.a, X2) ^ gf_mul(loc_i.b, X1) ^ loc_i.c) == '0);
    end
endmodule

// File: rtl/bch_codec.sv
module bch_codec
    import bch_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [bch_pkg::K-1:0] enc_data_i,
    output logic [bch_pkg::P-1:0] enc_parity_o,
    input  logic [bch_pkg::N-1:0] dec_word_i,
    output logic [bch_pkg::K-1:0] dec_data_o,
    output logic [1:0]            dec_nerr_o,
    output logic                  dec_fail_o
);
    gf_t          s1;
    gf_t          s3;
    loc_t         loc;
    logic [N-1:0] hit;
    logic [CW-1:0] nroot;
    dec_kind_e    kind;
    logic [N-1:0] fixed;
    dec_res_t     res;
    dec_res_t     res_q;

    bch_encoder u_enc (.data_i(enc_data_i), .parity_o(enc_parity_o));
    bch_syndrome u_syn (.word_i(dec_word_i), .s1_o(s1), .s3_o(s3));
    bch_locator u_loc (.s1_i(s1), .s3_i(s3), .loc_o(loc));
    bch_root_search u_roots (.loc_i(loc), .hit_o(hit));

    always_comb begin
        nroot = '0;
        for (int j = 0; j < N; j++) nroot = nroot + {{(CW-1){1'b0}}, hit[j]};
    end

    always_comb begin
        if (s1 == '0 && s3 == '0)
            kind = DK_CLEAN;
        else if (s1 != '0 && loc.c == '0 && nroot == CW'(1))
            kind = DK_ONE;
        else if (s1 != '0 && loc.c != '0 && nroot == CW'(2))
            kind = DK_TWO;
        else
            kind = DK_BAD;
    end

    always_comb begin
        fixed     = dec_word_i ^ ((kind == DK_ONE || kind == DK_TWO) ? hit : '0);
        res.data  = fixed[N-1:P];
        res.nerr  = (kind == DK_ONE) ? 2'd1 : (kind == DK_TWO) ? 2'd2 : 2'd0;
        res.fail  = (kind == DK_BAD);
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) res_q <= '0;
            else     res_q <= res;
        end
    end else begin : g_flow
        assign res_q = res;
    end

    assign dec_data_o = res_q.data;
    assign dec_nerr_o = res_q.nerr;
    assign dec_fail_o = res_q.fail;
endmodule

// File: rtl/bch_codec_chk.sv
module bch_codec_chk
    import bch_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic [K-1:0] word_data_i,
    input logic [K-1:0] dec_data_o,
    input logic [1:0]   dec_nerr_o,
    input logic         dec_fail_o
);
    logic [K-1:0] din_q;
    logic         armed_q;
    logic         rst_d;
    logic [K-1:0] ref_data;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            armed_q <= 1'b0;
            din_q   <= '0;
        end else begin
            armed_q <= 1'b1;
            din_q   <= word_data_i;
        end
    end

    assign ref_data = REG_OUT ? din_q : word_data_i;

    // R11
    nerr_range_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> dec_nerr_o != 2'd3);

    // R7
    fail_pass_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && dec_fail_o |-> dec_data_o == ref_data && dec_nerr_o == 2'd0);

    // R10
    flip_bound_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> $countones(dec_data_o ^ ref_data) <= int'(dec_nerr_o));

    // R9
    reset_zero_chk: assert property (@(posedge clk)
        rst_d && REG_OUT |-> dec_data_o == '0 && dec_nerr_o == 2'd0 && !dec_fail_o);
endmodule

bind bch_codec bch_codec_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_data_i(dec_word_i[bch_pkg::N-1:bch_pkg::P]),
    .dec_data_o (dec_data_o),
    .dec_nerr_o (dec_nerr_o),
    .dec_fail_o (dec_fail_o)
);

// File: tb/bch_codec_bench.sv
module bch_codec_bench;
    localparam int CLK_PERIOD = 10;
    localparam int KB = 256;
    localparam int PB = 18;
    localparam int NB = KB + PB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [KB-1:0] enc_data_i = '0;
    logic [PB-1:0] enc_parity_o;
    logic [NB-1:0] dec_word_i = '0;
    logic [KB-1:0] dec_data_o;
    logic [1:0]    dec_nerr_o;
    logic          dec_fail_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bch_codec u_bch_codec (
        .clk(clk), .rst(rst),
        .enc_data_i(enc_data_i), .enc_parity_o(enc_parity_o),
        .dec_word_i(dec_word_i), .dec_data_o(dec_data_o),
        .dec_nerr_o(dec_nerr_o), .dec_fail_o(dec_fail_o)
    );

    // Bit-serial field multiply, modulus x^9 + x^4 + 1.
    function automatic int fmul(int x, int y);
        int acc = 0;
        while (y != 0) begin
            if (y & 1) acc = acc ^ x;
            y = y >> 1;
            x = x << 1;
            if (x & 512) x = x ^ 529;
        end
        return acc;
    endfunction

    // Horner evaluation of the stored word at alpha^pw.
    function automatic int eval_at(logic [NB-1:0] w, int pw);
        int base = 1;
        int s = 0;
        for (int i = 0; i < pw; i++) base = fmul(base, 2);
        for (int j = NB - 1; j >= 0; j--) s = fmul(s, base) ^ int'(w[j]);
        return s;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [KB-1:0] act, input logic [KB-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [KB-1:0] rand_data();
        logic [KB-1:0] d;
        for (int w = 0; w < KB / 32; w++) d[w*32 +: 32] = $urandom;
        return d;
    endfunction

    function automatic logic [NB-1:0] rand_mask(int nflip);
        logic [NB-1:0] m = '0;
        while ($countones(m) < nflip) m[$urandom_range(NB - 1, 0)] = 1'b1;
        return m;
    endfunction

    task automatic run_case(input logic [KB-1:0] data, input logic [NB-1:0] mask);
        logic [NB-1:0] cw;
        logic [NB-1:0] rx;
        int nflip;
        bit parity_only;
        @(negedge clk);
        enc_data_i = data;
        #1;
        cw = {data, enc_parity_o};
        // R1: codeword vanishes at alpha and alpha^3
        check(eval_at(cw, 1) == 0 && eval_at(cw, 3) == 0, "R1 codeword roots",
              KB'(enc_parity_o), '0);
        nflip = $countones(mask);
        parity_only = (nflip > 0) && (mask[NB-1:PB] == '0);
        rx = cw ^ mask;
        dec_word_i = rx;
        @(negedge clk);
        if (nflip == 0) begin
            check(dec_data_o == data && dec_nerr_o == 2'd0 && !dec_fail_o,
                  "R3 clean word", {dec_data_o[KB-1:3], dec_nerr_o, dec_fail_o}, data);
        end else if (nflip <= 2) begin
            check(dec_data_o == data && int'(dec_nerr_o) == nflip && !dec_fail_o,
                  parity_only ? "R6 check-only flips" : (nflip == 1 ? "R4 one flip" : "R5 two flips"),
                  dec_data_o, data);
            check(int'(dec_nerr_o) == nflip, "R4 R5 count", KB'(dec_nerr_o), KB'(nflip));
        end else begin
            if (dec_fail_o)
                check(dec_data_o == rx[NB-1:PB] && dec_nerr_o == 2'd0,
                      "R7 pass-through", dec_data_o, rx[NB-1:PB]);
            else
                check(dec_nerr_o == 2'd2 && $countones(dec_data_o ^ rx[NB-1:PB]) <= 2,
                      "R8 three flips", KB'(dec_nerr_o), KB'(2));
        end
    endtask

    initial begin
        logic [NB-1:0] m;
        // R9: reset clears outputs even with a word present
        dec_word_i = {NB{1'b1}};
        repeat (3) @(negedge clk);
        check(dec_data_o == '0 && dec_nerr_o == 2'd0 && !dec_fail_o,
              "R9 reset state", dec_data_o, '0);

        // R2: zero data gives zero check bits
        enc_data_i = '0;
        #1;
        check(enc_parity_o == '0, "R2 zero parity", KB'(enc_parity_o), '0);

        // R9: latency, output changes only at the edge
        @(negedge clk);
        rst = 1'b0;
        dec_word_i = '0;
        dec_word_i[100] = 1'b1;
        #1;
        check(dec_nerr_o == 2'd0 && dec_data_o == '0, "R9 held before edge",
              KB'(dec_nerr_o), '0);
        @(negedge clk);
        check(dec_nerr_o == 2'd1 && dec_data_o == '0, "R9 updated after edge",
              KB'(dec_nerr_o), KB'(1));

        // Boundary positions (R4, R5) and check-only flips (R6)
        m = '0; m[0] = 1'b1;             run_case(rand_data(), m);
        m = '0; m[NB-1] = 1'b1;          run_case(rand_data(), m);
        m = '0; m[0] = 1'b1; m[NB-1] = 1'b1; run_case(rand_data(), m);
        m = '0; m[5] = 1'b1; m[17] = 1'b1;   run_case(rand_data(), m);
        m = '0; m[PB] = 1'b1; m[PB-1] = 1'b1; run_case({KB{1'b1}}, m);
        run_case('0, '0);
        run_case({KB{1'b1}}, '0);

        for (int n = 0; n < 4; n++)
            for (int v = 0; v < 100; v++)
                run_case(rand_data(), rand_mask(n));

        // R9: mid-run reset clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(dec_data_o == '0 && dec_nerr_o == 2'd0 && !dec_fail_o,
              "R9 mid-run reset", dec_data_o, '0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule